// File: doc/BRIEF.md
# Gated-Carry Ripple Arithmetic Logic Unit

This block computes one of six distinct logic or arithmetic results from two W-bit operands. A ripple chain of identical one-bit full-adder slices forms the datapath. The three select lines drive the datapath directly, with no decoding table in front of them. One select bit flips operand B before it enters every slice. A second bit lets carries pass between slices; when it is low, every slice adds with a zero carry and the chain becomes a bitwise exclusive-or. The third bit is the carry fed into the lowest slice. Because the select lines act this directly, the eight codes contain two redundant pairs.

The combinational result and its carry-out are held in an output register. A caller presents operands and a select code, and reads the result one clock later. Subtraction is done by adding the one's complement of B with a carry-in of one. The carry-out then reports whether a borrow occurred.

Top module: `gc_alu`

## Requirements
- R1: Select bit 0 (`fsel[0]`) inverts every bit of B before it reaches its slice. With `fsel[1]=0`, `fsel=001` yields A XNOR B, whereas `fsel=000` yields A XOR B.
- R2: When `fsel[1]=0`, `res` equals A XOR B XOR {W{fsel[0]}}, whatever the value of `fsel[2]`. So code 100 matches 000, and code 101 matches 001.
- R3: When `fsel[1]=0`, `cout` equals A[W-1] AND (B[W-1] XOR fsel[0]). This is the top slice computed with its incoming carry forced to zero.
- R4: `fsel=010` gives {cout,res} = A + B.
- R5: `fsel=110` gives {cout,res} = A + B + 1.
- R6: `fsel=011` gives {cout,res} = A + ~B, which is A − B − 1 modulo 2^W, with the carry out of the top bit in `cout`.
- R7: `fsel=111` gives {cout,res} = A + ~B + 1, so `res` = A − B. `cout` is 1 exactly when A ≥ B unsigned (no borrow) and 0 when a borrow occurs.
- R8: The carry ripples from bit 0 up to bit W−1, and `fsel[2]` is the carry into bit 0. For example, all-ones plus zero with `fsel=110` carries through every bit and gives `res=0` with `cout=1`.
- R9: `res` and `cout` reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low they are cleared to zero at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | W | Operand A |
| op_b | input | W | Operand B |
| fsel | input | 3 | Select: bit 0 inverts B, bit 1 enables carries, bit 2 is the carry into bit 0 |
| res | output | W | Registered result |
| cout | output | 1 | Registered carry out of the top slice |

## Verification
A 4-bit instance is driven through every operand pair under all eight codes. Against an independent model, this separates the XOR/XNOR path from the carry path and shows that the redundant codes match their twins. Directed 8-bit vectors pick out the cases that a single wrong gate would disturb. These include a carry that runs the full length of the chain, subtraction with equal operands, subtraction with and without a borrow, and logic-mode carry-outs with the top bits set. Random 8-bit vectors across all codes then cover the remaining combinations. A mid-run reset shows that the register clears.

// File: rtl/gc_alu_pkg.sv
`timescale 1ns/1ps
package gc_alu_pkg;

    typedef struct packed {
        logic inv_b;      // select bit 0
        logic carry_en;   // select bit 1
        logic carry_lsb;  // select bit 2
    } alu_ctl_t;

    function automatic alu_ctl_t split_sel(input logic [2:0] sel);
        alu_ctl_t c;
        c.inv_b     = sel[0];
        c.carry_en  = sel[1];
        c.carry_lsb = sel[2];
        return c;
    endfunction

endpackage

// File: rtl/gc_slice.sv
`timescale 1ns/1ps
// One bit of the datapath: conditional B inversion, gated carry-in, full add.
module gc_slice (
    input  logic a_bit,
    input  logic b_bit,
    input  logic inv_b,
    input  logic carry_en,
    input  logic carry_in,
    output logic sum_bit,
    output logic carry_out
);
    logic b_eff;
    logic c_eff;
    logic half;

    always_comb begin
        b_eff     = b_bit ^ inv_b;
        c_eff     = carry_in & carry_en;
        half      = a_bit ^ b_eff;
        sum_bit   = half ^ c_eff;
        carry_out = (a_bit & b_eff) | (half & c_eff);
    end
endmodule

// File: rtl/gc_ripple.sv
`timescale 1ns/1ps
// Chain of W slices, carry running from bit 0 upward.
module gc_ripple
    import gc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] sum,
    output logic         carry_top
);
    localparam int NCARRY = W + 1;

    logic [NCARRY-1:0] chain;

    assign chain[0]  = ctl.carry_lsb;
    assign carry_top = chain[NCARRY-1];

    for (genvar i = 0; i < W; i++) begin : g_bit
        gc_slice u_slice (
            .a_bit     (a[i]),
            .b_bit     (b[i]),
            .inv_b     (ctl.inv_b),
            .carry_en  (ctl.carry_en),
            .carry_in  (chain[i]),
            .sum_bit   (sum[i]),
            .carry_out (chain[i+1])
        );
    end
endmodule

// File: rtl/gc_alu.sv
`timescale 1ns/1ps
module gc_alu
    import gc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   fsel,
    output logic [W-1:0] res,
    output logic         cout
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
    } out_t;

    alu_ctl_t     ctl;
    logic [W-1:0] sum_w;
    logic         carry_w;
    out_t         out_d;
    out_t         out_q;

    assign ctl = split_sel(fsel);

    gc_ripple #(.W(W)) u_chain (
        .a         (op_a),
        .b         (op_b),
        .ctl       (ctl),
        .sum       (sum_w),
        .carry_top (carry_w)
    );

    always_comb begin
        out_d      = out_q;
        out_d.res  = sum_w;
        out_d.cout = carry_w;
        if (!rst_n) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign res  = out_q.res;
    assign cout = out_q.cout;
endmodule

// File: rtl/gc_alu_chk.sv
`timescale 1ns/1ps
module gc_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [2:0]   fsel,
    input logic [W-1:0] res,
    input logic         cout
);
    assert_logic_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsel[1]) |=> (res == ($past(op_a) ^ $past(op_b) ^ {W{$past(fsel[0])}})));

    assert_logic_cout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsel[1]) |=> (cout == ($past(op_a[W-1]) & ($past(op_b[W-1]) ^ $past(fsel[0])))));

    assert_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 3'b010) |=> ({cout, res} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

    assert_sub_borrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 3'b111) |=> ((res == W'($past(op_a) - $past(op_b)))
                              && (cout == ($past(op_a) >= $past(op_b)))));

    assert_reset_clear_R9: assert property (@(posedge clk)
        (!rst_n) |=> (res == '0 && !cout));
endmodule

bind gc_alu gc_alu_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .fsel  (fsel),
    .res   (res),
    .cout  (cout)
);

// File: tb/gc_alu_tb.sv
`timescale 1ns/1ps
module gc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a8 = '0, b8 = '0;
    logic [2:0] f8 = '0;
    logic [7:0] r8;
    logic       c8;
    logic [3:0] a4 = '0, b4 = '0;
    logic [2:0] f4 = '0;
    logic [3:0] r4;
    logic       c4;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    gc_alu #(.W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .fsel(f8), .res(r8), .cout(c8));

    gc_alu #(.W(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .fsel(f4), .res(r4), .cout(c4));

    // {a, b, fsel, cout, res}
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {8'h5A, 8'h0F, 3'b000, 1'b0, 8'h55},
        {8'h5A, 8'h0F, 3'b001, 1'b0, 8'hAA},
        {8'hC3, 8'h81, 3'b100, 1'b1, 8'h42},
        {8'hC3, 8'h81, 3'b101, 1'b0, 8'hBD},
        {8'h64, 8'h32, 3'b010, 1'b0, 8'h96},
        {8'hF0, 8'h20, 3'b010, 1'b1, 8'h10},
        {8'hFF, 8'h00, 3'b110, 1'b1, 8'h00},
        {8'h10, 8'h05, 3'b011, 1'b1, 8'h0A},
        {8'h10, 8'h05, 3'b111, 1'b1, 8'h0B},
        {8'h05, 8'h10, 3'b111, 1'b0, 8'hF5},
        {8'h20, 8'h20, 3'b111, 1'b1, 8'h00},
        {8'h00, 8'h00, 3'b011, 1'b0, 8'hFF}
    };

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'b000, 3'b100: return "R2";
            3'b001, 3'b101: return "R1";
            3'b010:         return "R4";
            3'b110:         return "R5";
            3'b011:         return "R6";
            default:        return "R7";
        endcase
    endfunction

    // Behavioural model: {cout, res} for width w (<= 8).
    function automatic logic [8:0] model(input int w, input logic [7:0] a,
                                         input logic [7:0] b, input logic [2:0] f);
        logic [8:0] mask, t, nb;
        mask = (9'd1 << w) - 9'd1;
        nb   = {1'b0, ~b} & mask;
        case (f)
            3'b000, 3'b100: t = ({1'b0, a ^ b} & mask) | ((a[w-1] & b[w-1]) ? (9'd1 << w) : 9'd0);
            3'b001, 3'b101: t = ({1'b0, a} ^ nb) | ((a[w-1] & ~b[w-1]) ? (9'd1 << w) : 9'd0);
            3'b010:         t = {1'b0, a} + {1'b0, b};
            3'b110:         t = {1'b0, a} + {1'b0, b} + 9'd1;
            3'b011:         t = {1'b0, a} + nb;
            default:        t = {1'b0, a} + nb + 9'd1;
        endcase
        return t & ((mask << 1) | 9'd1);
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic [2:0] f,
                        input string req, input logic [8:0] exp);
        @(negedge clk);
        a8 = a; b8 = b; f8 = f;
        @(negedge clk);
        check(req, {c8, r8}, exp);
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset clears outputs
        a8 = 8'hFF; b8 = 8'h01; f8 = 3'b010;
        repeat (3) @(negedge clk);
        check("R9", {c8, r8}, 9'h000);
        check("R9", {1'b0, c4, r4}, 9'h000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string tag;
            v = VEC[i];
            tag = (i == 6) ? "R8" : (i == 2 || i == 3) ? "R3" : req_of(v[11:9]);
            run8(v[27:20], v[19:12], v[11:9], tag, v[8:0]);
        end

        // Exhaustive 4-bit, every code
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(negedge clk);
                    a4 = 4'(a); b4 = 4'(b); f4 = 3'(f);
                    @(negedge clk);
                    check(req_of(3'(f)), {4'b0, c4, r4}, model(4, 8'(a), 8'(b), 3'(f)));
                end
            end
        end

        // Random 8-bit
        for (int k = 0; k < 800; k++) begin
            logic [7:0] ra, rb;
            logic [2:0] rf;
            ra = 8'($urandom); rb = 8'($urandom); rf = 3'(k);
            run8(ra, rb, rf, req_of(rf), model(8, ra, rb, rf));
        end

        // R9: mid-run reset clears outputs
        @(negedge clk);
        a8 = 8'h7F; b8 = 8'h7F; f8 = 3'b110;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", {c8, r8}, 9'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {c8, r8}, 9'h0FF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule